// File: doc/BRIEF.md
# Composite Raster Timing Generator

This block produces the raster timing for a standard-definition composite video encoder. It runs on the pixel-rate clock and keeps a pixel counter within the line, a line counter within the frame and a field sequence counter. From these it drives active-low horizontal and vertical sync, a composite blanking flag and an active-pixel window. The pixel data path uses the window to decide which input samples become picture content.

A 2-bit mode input selects between NTSC and PAL line structures, each either interlaced or progressive. In progressive mode every field is an odd field with one extra half line, and the second field is never produced. Two resets are provided. The synchronous active-low master reset parks the raster at a known point inside field 1. The active-high timing reset holds the generator idle and, once released, starts the raster at the top of field 1. The data path does not need to be reset for this, so the raster can be realigned on its own.

Top module: `vtg_core`

## Requirements
- R1: `mode[1]` selects PAL (1) or NTSC (0), and `mode[0]` selects progressive (1) or interlaced (0). An interlaced frame has 525 lines (NTSC) or 625 lines (PAL), numbered from 1. After its last line, `line_num` returns to 1 with `pix_num` at 0.
- R2: A line lasts `NTSC_LINE` (default 796) or `PAL_LINE` (default 944) pixel clocks. `pix_num` counts from 0 up to the line length minus 1, and then `line_num` advances.
- R3: `hs_n` is low for the first `NTSC_HS` (default 59) or `PAL_HS` pixel clocks of every line, including the lines inside the vertical sync interval.
- R4: `active` is high from `HS width + delay` clocks into the line (delay `NTSC_DLY`=48, `PAL_DLY`=58) for `NTSC_AW` or `PAL_AW` clocks, but only outside vertical blanking. `cblank` is always the inverse of `active`.
- R5: NTSC vertical blanking covers lines 523–525, 1–17 and 261–279, the second half of line 260 and the first half of line 280. A half is `pix_num` below or at/above half the line length.
- R6: PAL vertical blanking covers lines 624–625, 1–22 and 311–335, the second half of line 623 and the first half of line 23.
- R7: NTSC `vs_n` is low for 3 lines per field. In field 1 it runs from line 1 pixel 0 to the end of line 3. In field 2 it runs from the middle of line 263 to the middle of line 266. A `vs_n` fall that coincides with an `hs_n` fall marks an odd field.
- R8: PAL `vs_n` is low for 2.5 lines per field. In field 1 it runs from line 1 pixel 0 to the middle of line 3. In field 2 it runs from the middle of line 313 to the end of line 315.
- R9: In progressive mode a field has 263 (NTSC) or 313 (PAL) lines. It then returns to line 1. `odd_field` stays 1 and no mid-line `vs_n` fall occurs.
- R10: `field_seq` increments at each field start (line 1 pixel 0, and in interlaced mode the middle of line 263 or 313). It wraps modulo 4 in NTSC and modulo 8 in PAL. `odd_field` is 1 when `field_seq` is even or the mode is progressive.
- R11: With `rst_n` low at a clock edge, the raster goes to line 64, pixel 0 (the start of horizontal sync), with `field_seq` 0.
- R12: While `tim_rst` is high, the generator holds with `hs_n` and `vs_n` high, `active` low, line 1 and pixel 0. On the first clock edge after release, line 1 pixel 0 of field 1 begins, with `hs_n` and `vs_n` falling together and `field_seq` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Synchronous master reset, active low |
| tim_rst | input | 1 | Synchronous timing restart, active high |
| mode | input | 2 | [1] PAL, [0] progressive |
| hs_n | output | 1 | Horizontal sync, active low |
| vs_n | output | 1 | Vertical sync, active low |
| cblank | output | 1 | Composite blanking flag |
| active | output | 1 | Active-pixel window |
| line_num | output | 10 | Current line, 1-based |
| pix_num | output | PIX_W | Pixel position within the line |
| field_seq | output | 3 | Field sequence count |
| odd_field | output | 1 | Current field is odd |

## Verification
The bench targets the half-line edges. The field 2 sync starts and the half-blanked lines are where an off-by-one comparison would shift a sync fall by one pixel or blank a whole line instead of half. It checks the frame wrap in all four modes. A generator that kept the interlaced line count in progressive mode would run past line 263 or 313, and one that still produced the mid-line field 2 sync would clear `odd_field`. It also checks the two resets against their different landing points. Confusing the two would start at line 1 after a master reset, or resume mid-frame after a timing restart.

// File: rtl/vtg_core.sv
module vtg_core #(
  parameter int NTSC_LINE = 796,
  parameter int PAL_LINE  = 944,
  parameter int NTSC_HS   = 59,
  parameter int PAL_HS    = 70,
  parameter int NTSC_DLY  = 48,
  parameter int PAL_DLY   = 58,
  parameter int NTSC_AW   = 640,
  parameter int PAL_AW    = 768,
  parameter int PIX_W     = $clog2((NTSC_LINE > PAL_LINE) ? NTSC_LINE : PAL_LINE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tim_rst,
  input  logic [1:0]       mode,
  output logic             hs_n,
  output logic             vs_n,
  output logic             cblank,
  output logic             active,
  output logic [9:0]       line_num,
  output logic [PIX_W-1:0] pix_num,
  output logic [2:0]       field_seq,
  output logic             odd_field
);

  localparam logic [PIX_W-1:0] N_LEN = PIX_W'(NTSC_LINE);
  localparam logic [PIX_W-1:0] P_LEN = PIX_W'(PAL_LINE);
  localparam logic [PIX_W-1:0] N_HSW = PIX_W'(NTSC_HS);
  localparam logic [PIX_W-1:0] P_HSW = PIX_W'(PAL_HS);
  localparam logic [PIX_W-1:0] N_BEG = PIX_W'(NTSC_HS + NTSC_DLY);
  localparam logic [PIX_W-1:0] P_BEG = PIX_W'(PAL_HS + PAL_DLY);
  localparam logic [PIX_W-1:0] N_END = PIX_W'(NTSC_HS + NTSC_DLY + NTSC_AW);
  localparam logic [PIX_W-1:0] P_END = PIX_W'(PAL_HS + PAL_DLY + PAL_AW);

  function automatic logic in_rng(input logic [9:0] l, input logic [9:0] lo, input logic [9:0] hi);
    return (l >= lo) && (l <= hi);
  endfunction

  logic             pal, prog, hold;
  logic [PIX_W-1:0] len, half, hsw, a_beg, a_end;
  logic [PIX_W-1:0] pix_nx;
  logic [9:0]       nlines, f2_line, line_nx;
  logic [2:0]       seq_mask;
  logic             last_pix, fstart_nx, first_half;
  logic             vb_ntsc, vb_pal, vblank;
  logic             vs_ntsc, vs_pal, vs_on, hwin;

  assign pal  = mode[1];
  assign prog = mode[0];

  assign len      = pal ? P_LEN : N_LEN;
  assign half     = len >> 1;
  assign hsw      = pal ? P_HSW : N_HSW;
  assign a_beg    = pal ? P_BEG : N_BEG;
  assign a_end    = pal ? P_END : N_END;
  assign nlines   = pal ? (prog ? 10'd313 : 10'd625) : (prog ? 10'd263 : 10'd525);
  assign f2_line  = pal ? 10'd313 : 10'd263;
  assign seq_mask = pal ? 3'd7 : 3'd3;

  assign last_pix = pix_num >= len - 1'b1;
  assign pix_nx   = last_pix ? '0 : pix_num + 1'b1;
  assign line_nx  = !last_pix ? line_num :
                    (line_num >= nlines) ? 10'd1 : line_num + 10'd1;
  assign fstart_nx = (pix_nx == '0 && line_nx == 10'd1) ||
                     (!prog && line_nx == f2_line && pix_nx == half);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_num   <= '0;
      line_num  <= 10'd64;
      field_seq <= 3'd0;
      hold      <= 1'b0;
    end else if (tim_rst) begin
      pix_num   <= '0;
      line_num  <= 10'd1;
      field_seq <= 3'd0;
      hold      <= 1'b1;
    end else if (hold) begin
      hold <= 1'b0;
    end else begin
      pix_num  <= pix_nx;
      line_num <= line_nx;
      if (fstart_nx)
        field_seq <= (field_seq + 3'd1) & seq_mask;
    end
  end

  assign first_half = pix_num < half;

  assign vb_ntsc = in_rng(line_num, 10'd1, 10'd17)   ||
                   in_rng(line_num, 10'd261, 10'd279) ||
                   in_rng(line_num, 10'd523, 10'd525) ||
                   (line_num == 10'd260 && !first_half) ||
                   (line_num == 10'd280 && first_half);

  assign vb_pal  = in_rng(line_num, 10'd1, 10'd22)   ||
                   in_rng(line_num, 10'd311, 10'd335) ||
                   in_rng(line_num, 10'd624, 10'd625) ||
                   (line_num == 10'd623 && !first_half) ||
                   (line_num == 10'd23 && first_half);

  assign vblank = pal ? vb_pal : vb_ntsc;

  assign vs_ntsc = in_rng(line_num, 10'd1, 10'd3) ||
                   (!prog && ((line_num == 10'd263 && !first_half) ||
                              in_rng(line_num, 10'd264, 10'd265) ||
                              (line_num == 10'd266 && first_half)));

  assign vs_pal  = in_rng(line_num, 10'd1, 10'd2) ||
                   (line_num == 10'd3 && first_half) ||
                   (!prog && ((line_num == 10'd313 && !first_half) ||
                              in_rng(line_num, 10'd314, 10'd315)));

  assign vs_on = pal ? vs_pal : vs_ntsc;
  assign hwin  = (pix_num >= a_beg) && (pix_num < a_end);

  assign hs_n      = hold || (pix_num >= hsw);
  assign vs_n      = hold || !vs_on;
  assign active    = !hold && hwin && !vblank;
  assign cblank    = !active;
  assign odd_field = prog || !field_seq[0];

endmodule

// File: rtl/vtg_core_chk.sv
module vtg_core_chk #(
  parameter int NTSC_LINE = 796,
  parameter int PAL_LINE  = 944,
  parameter int NTSC_HS   = 59,
  parameter int PAL_HS    = 70,
  parameter int PIX_W     = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tim_rst,
  input logic [1:0]       mode,
  input logic             hs_n,
  input logic             vs_n,
  input logic             cblank,
  input logic             active,
  input logic [9:0]       line_num,
  input logic [PIX_W-1:0] pix_num,
  input logic [2:0]       field_seq,
  input logic             odd_field
);

  logic [PIX_W-1:0] lo_cnt, exp_hs, exp_len;
  logic [9:0]       max_line;

  assign exp_hs   = mode[1] ? PIX_W'(PAL_HS) : PIX_W'(NTSC_HS);
  assign exp_len  = mode[1] ? PIX_W'(PAL_LINE) : PIX_W'(NTSC_LINE);
  assign max_line = mode[1] ? (mode[0] ? 10'd313 : 10'd625) : (mode[0] ? 10'd263 : 10'd525);

  always_ff @(posedge clk) begin
    if (!rst_n)     lo_cnt <= '0;
    else if (!hs_n) lo_cnt <= lo_cnt + 1'b1;
    else            lo_cnt <= '0;
  end

  AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !tim_rst |-> (line_num >= 10'd1 && line_num <= max_line)); // R1

  AST_PIX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!tim_rst && pix_num == exp_len - 1'b1) |=> pix_num == '0); // R2

  AST_HS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_n) && !tim_rst && !$past(tim_rst)) |-> lo_cnt == exp_hs); // R3

  AST_VS_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_n |-> cblank); // R5

  AST_ODD_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(vs_n) && $fell(hs_n)) |-> odd_field); // R7

  AST_EVEN_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(vs_n) && hs_n && !tim_rst) |-> !odd_field); // R7

  AST_PROG_NO_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] && $fell(vs_n)) |-> !hs_n); // R9

  AST_SEQ_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tim_rst && !mode[1]) |-> field_seq < 3'd4); // R10

  AST_TRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tim_rst |=> (hs_n && vs_n && !active && line_num == 10'd1 && pix_num == '0)); // R12

  AST_TRST_GO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tim_rst) |=> (!hs_n && !vs_n && line_num == 10'd1 && field_seq == 3'd0)); // R12

endmodule

bind vtg_core vtg_core_chk #(
  .NTSC_LINE(NTSC_LINE), .PAL_LINE(PAL_LINE),
  .NTSC_HS(NTSC_HS), .PAL_HS(PAL_HS), .PIX_W(PIX_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .tim_rst(tim_rst), .mode(mode),
  .hs_n(hs_n), .vs_n(vs_n), .cblank(cblank), .active(active),
  .line_num(line_num), .pix_num(pix_num), .field_seq(field_seq),
  .odd_field(odd_field)
);

// File: tb/vtg_core_tb_top.sv
module vtg_core_tb_top;
  localparam int CLK_P = 10;
  localparam int NL = 80, PL = 88, NH = 8, PH = 10, ND = 6, PD = 7, NA = 50, PA = 60;
  localparam int PW = 7;

  logic clk = 1'b0, rst_n = 1'b0, tim_rst = 1'b0;
  logic [1:0] mode = 2'b00;
  logic hs_n, vs_n, cblank, active, odd_field;
  logic [9:0] line_num;
  logic [PW-1:0] pix_num;
  logic [2:0] field_seq;

  int checks = 0, fails = 0, pos = 0, cur_len = NL;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  vtg_core #(.NTSC_LINE(NL), .PAL_LINE(PL), .NTSC_HS(NH), .PAL_HS(PH),
             .NTSC_DLY(ND), .PAL_DLY(PD), .NTSC_AW(NA), .PAL_AW(PA), .PIX_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tim_rst(tim_rst), .mode(mode),
    .hs_n(hs_n), .vs_n(vs_n), .cblank(cblank), .active(active),
    .line_num(line_num), .pix_num(pix_num), .field_seq(field_seq), .odd_field(odd_field));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic seek(input int ln, input int px);
    int target;
    target = (ln - 1) * cur_len + px;
    repeat (target - pos) @(negedge clk);
    pos = target;
  endtask

  task automatic restart(input logic [1:0] m);
    mode = m;
    cur_len = m[1] ? PL : NL;
    tim_rst = 1'b1;
    @(negedge clk);
    chk(hs_n, 1, "R12 hold hs_n");
    chk(vs_n, 1, "R12 hold vs_n");
    chk(active, 0, "R12 hold active");
    @(negedge clk);
    chk(line_num, 1, "R12 hold line");
    chk(pix_num, 0, "R12 hold pix");
    tim_rst = 1'b0;
    @(negedge clk);
    pos = 0;
    chk(hs_n, 0, "R12 start hs_n");
    chk(vs_n, 0, "R12 start vs_n");
    chk(line_num, 1, "R12 start line");
    chk(pix_num, 0, "R12 start pix");
    chk(field_seq, 0, "R12 start seq");
    chk(odd_field, 1, "R12 start odd");
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(line_num, 64, "R11 reset line");
    chk(pix_num, 0, "R11 reset pix");
    chk(hs_n, 0, "R11 reset hs_n");
    chk(vs_n, 1, "R11 reset vs_n");
    chk(cblank, 1, "R11 reset cblank");
    chk(field_seq, 0, "R11 reset seq");
    chk(odd_field, 1, "R11 reset odd");
    @(negedge clk);
    chk(pix_num, 1, "R11 runs after reset");
  endtask

  task automatic t_ntsc;
    restart(2'b00);
    seek(2, 0);   chk(hs_n, 0, "R3 ntsc hs in vs");  chk(vs_n, 0, "R7 ntsc vs line2");
    seek(2, 8);   chk(hs_n, 1, "R3 ntsc hs end");    chk(vs_n, 0, "R7 ntsc vs held");
    seek(3, 79);  chk(vs_n, 0, "R7 ntsc vs line3 end");
    seek(4, 0);   chk(vs_n, 1, "R7 ntsc vs off");    chk(hs_n, 0, "R3 ntsc hs line4");
    seek(17, 30); chk(cblank, 1, "R5 ntsc line17 blank");
    seek(18, 30); chk(active, 1, "R5 ntsc line18 active");
    seek(20, 7);  chk(hs_n, 0, "R3 ntsc hs last low");
    seek(20, 8);  chk(hs_n, 1, "R3 ntsc hs rise");
    seek(20, 13); chk(active, 0, "R4 ntsc before window");
    seek(20, 14); chk(active, 1, "R4 ntsc window start"); chk(cblank, 0, "R4 ntsc cblank low");
    seek(20, 63); chk(active, 1, "R4 ntsc window last");
    seek(20, 64); chk(active, 0, "R4 ntsc window end");
    seek(20, 79); chk(line_num, 20, "R2 ntsc line end");
    seek(21, 0);  chk(line_num, 21, "R2 ntsc next line"); chk(pix_num, 0, "R2 ntsc pix wrap");
    seek(260, 20); chk(active, 1, "R5 ntsc 260 first half");
    seek(260, 45); chk(active, 0, "R5 ntsc 260 second half");
    seek(263, 39); chk(vs_n, 1, "R7 ntsc f2 vs before mid");
    seek(263, 40); chk(vs_n, 0, "R7 ntsc f2 vs mid");
    chk(hs_n, 1, "R7 ntsc f2 vs not with hs");
    chk(field_seq, 1, "R10 ntsc field2 seq"); chk(odd_field, 0, "R10 ntsc field2 even");
    seek(266, 39); chk(vs_n, 0, "R7 ntsc f2 vs last");
    seek(266, 40); chk(vs_n, 1, "R7 ntsc f2 vs off");
    seek(280, 20); chk(active, 0, "R5 ntsc 280 first half");
    seek(280, 45); chk(active, 1, "R5 ntsc 280 second half");
    seek(522, 30); chk(active, 1, "R5 ntsc 522 active");
    seek(523, 30); chk(cblank, 1, "R5 ntsc 523 blank");
    seek(526, 0); chk(line_num, 1, "R1 ntsc frame wrap"); chk(pix_num, 0, "R1 ntsc wrap pix");
    chk(field_seq, 2, "R10 ntsc third field"); chk(odd_field, 1, "R10 ntsc odd again");
    chk(vs_n, 0, "R7 ntsc vs new frame");
  endtask

  task automatic t_pal;
    restart(2'b10);
    seek(3, 43);  chk(vs_n, 0, "R8 pal vs line3 first half");
    seek(3, 44);  chk(vs_n, 1, "R8 pal vs off mid line3");
    seek(22, 30); chk(cblank, 1, "R6 pal line22 blank");
    seek(23, 20); chk(active, 0, "R6 pal 23 first half");
    seek(23, 50); chk(active, 1, "R6 pal 23 second half");
    seek(30, 9);  chk(hs_n, 0, "R3 pal hs last low");
    seek(30, 10); chk(hs_n, 1, "R3 pal hs rise");
    seek(30, 16); chk(active, 0, "R4 pal before window");
    seek(30, 17); chk(active, 1, "R4 pal window start");
    seek(310, 30); chk(active, 1, "R6 pal 310 active");
    seek(311, 30); chk(cblank, 1, "R6 pal 311 blank");
    seek(313, 43); chk(vs_n, 1, "R8 pal f2 before mid"); chk(field_seq, 0, "R10 pal seq f1");
    seek(313, 44); chk(vs_n, 0, "R8 pal f2 vs mid");
    chk(field_seq, 1, "R10 pal seq f2"); chk(odd_field, 0, "R10 pal even");
    seek(315, 87); chk(vs_n, 0, "R8 pal f2 vs last");
    seek(316, 0);  chk(vs_n, 1, "R8 pal f2 vs off");
    seek(335, 30); chk(cblank, 1, "R6 pal 335 blank");
    seek(336, 30); chk(active, 1, "R6 pal 336 active");
    seek(623, 30); chk(active, 1, "R6 pal 623 first half");
    seek(623, 50); chk(active, 0, "R6 pal 623 second half");
    seek(624, 30); chk(cblank, 1, "R6 pal 624 blank");
    seek(626, 0);  chk(line_num, 1, "R1 pal frame wrap"); chk(field_seq, 2, "R10 pal third field");
  endtask

  task automatic t_prog_ntsc;
    restart(2'b01);
    seek(263, 39); chk(line_num, 263, "R9 prog ntsc line 263");
    seek(263, 40); chk(vs_n, 1, "R9 prog ntsc no f2 vs"); chk(odd_field, 1, "R9 prog ntsc odd");
    seek(264, 0);  chk(line_num, 1, "R9 prog ntsc wrap"); chk(vs_n, 0, "R9 prog ntsc vs");
    chk(odd_field, 1, "R9 prog ntsc odd next"); chk(field_seq, 1, "R10 prog ntsc seq");
  endtask

  task automatic t_prog_pal;
    restart(2'b11);
    seek(313, 44); chk(vs_n, 1, "R9 prog pal no f2 vs"); chk(line_num, 313, "R9 prog pal line 313");
    seek(314, 0);  chk(line_num, 1, "R9 prog pal wrap"); chk(vs_n, 0, "R9 prog pal vs");
    chk(odd_field, 1, "R9 prog pal odd");
  endtask

  initial begin
    t_reset;
    t_ntsc;
    t_pal;
    t_prog_ntsc;
    t_prog_pal;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", pos, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule